// File: doc/BRIEF.md
# Delta-Sigma Converter Digital Back-End

This block is the logic half of a first-order delta-sigma analog-to-digital converter that needs only a resistor-capacitor network and a differential input pin outside the chip. The differential input compares the RC node against a reference near half the supply. The block registers that decision on every clock and drives it straight back out as the feedback bit. The feedback charges or discharges the RC node, so the loop keeps the node close to the reference and the comparator never has to follow the full input swing.

The block also drives a square wave with an exact 50 % duty cycle. After RC filtering, its average is a half-supply reference that follows the rail, and several converter channels can share it. The bitstream is decimated by an integrate-and-dump counter. The counter sums the feedback ones over a window of 2^N clocks, loads an N-bit result, pulses a strobe, and starts the next window on the very next sample.

The comparator decision enters as an asynchronous level and passes through a synchroniser first. The reset asserts asynchronously and must be released in step with the clock.

Top module: `sdadc_backend`

## Requirements
- R1: While rst_n is low, fb_out, ref_out, result and result_valid are all 0, and they remain 0 at the first falling clock edge after a reset that is asserted in the middle of a window.
- R2: fb_out equals the value that cmp_in held three rising edges earlier. Two edges are spent in the synchroniser and one in the feedback register.
- R3: ref_out starts low after reset and inverts every REF_HALF_PERIOD rising edges. Its high and low times are therefore equal.
- R4: result_valid is high for exactly one cycle after every 2^N rising edges counted from reset release, and it is low at all other times.
- R5: On each result_valid pulse, result equals the number of rising edges within that window at which fb_out was 1. Consecutive windows cover every sample with no gap and no overlap.
- R6: A window whose 2^N samples are all 1 reports 2^N-1 instead of wrapping to 0.
- R7: A window whose samples are all 0 reports 0.
- R8: With the loop closed around a model integrator whose input level is x/2^N of full scale, the mean of successive results is within ±2 LSB of x, capped at 2^N-1.
- R9: result does not change between result_valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator sample clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| cmp_in | input | 1 | Asynchronous comparator decision from the differential input pin |
| fb_out | output | 1 | Registered feedback bit that drives the RC integrator |
| ref_out | output | 1 | 50 % duty square wave; its filtered average is the half-supply reference |
| result | output | N | Count of feedback ones in the last window, saturated |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench first drives the comparator open-loop. It uses all-zero, all-one, alternating and pseudo-random patterns to test the three-cycle feedback latency, the window sums and the window boundaries. A counter that wrapped would report 0 on the all-ones window. An off-by-one window would move the strobe, or count one sample twice or drop one, and either fault breaks the exact sum check. The bench then closes the loop around a model integrator and sweeps every input level from 0 to full scale, so a wrong feedback polarity or extra latency shows up as a mean far from the input. A reset in the middle of a window confirms that the outputs clear and that the window phase restarts from the release.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

  // Default depth of the comparator synchroniser.
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  // Number of samples in a decimation window for a result width of n bits.
  function automatic int unsigned window_len(input int unsigned n);
    return 32'd1 << n;
  endfunction

endpackage

// File: rtl/sdadc_sync.sv
module sdadc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= 1'b0;
        else        stage_q[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= 1'b0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sdadc_ref_gen.sv
module sdadc_ref_gen #(
  parameter int unsigned HALF_PERIOD = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_out
);

  localparam int unsigned CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ref_q, ref_d;
  logic          flip;

  always_comb begin
    flip  = (cnt_q == LAST);
    cnt_d = flip ? '0 : cnt_q + CW'(1);
    ref_d = flip ? ~ref_q : ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ref_q <= ref_d;
    end
  end

  assign ref_out = ref_q;

  // R3
  ref_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/sdadc_decim.sv
module sdadc_decim #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  output logic [N-1:0] result,
  output logic         result_valid
);

  localparam int unsigned W  = sdadc_pkg::window_len(N);
  localparam int unsigned AW = N + 1;

  logic [N-1:0]  idx_q, idx_d;
  logic [AW-1:0] acc_q, acc_d, sum_w;
  logic [N-1:0]  res_q, res_d;
  logic          vld_q, vld_d;
  logic          win_end;

  always_comb begin
    win_end = (idx_q == {N{1'b1}});
    sum_w   = acc_q + AW'(bit_in);
    idx_d   = idx_q + N'(1);
    acc_d   = win_end ? '0 : sum_w;
    vld_d   = win_end;
    res_d   = sum_w[N] ? {N{1'b1}} : sum_w[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      acc_q <= acc_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (win_end) res_q <= res_d;
  end

  assign result       = res_q;
  assign result_valid = vld_q;

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(acc_q) == AW'(W - 1) && $past(bit_in)) |-> (res_q == {N{1'b1}}));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(res_q));

endmodule

// File: rtl/sdadc_backend.sv
module sdadc_backend #(
  parameter int unsigned N               = 10,
  parameter int unsigned SYNC_STAGES     = sdadc_pkg::SYNC_DEPTH_DEF,
  parameter int unsigned REF_HALF_PERIOD = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_in,
  output logic         fb_out,
  output logic         ref_out,
  output logic [N-1:0] result,
  output logic         result_valid
);

  logic cmp_sync;
  logic fb_q, fb_d;

  sdadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmp_in),
    .q     (cmp_sync)
  );

  always_comb fb_d = cmp_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= fb_d;
  end

  assign fb_out = fb_q;

  sdadc_ref_gen #(.HALF_PERIOD(REF_HALF_PERIOD)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_out (ref_out)
  );

  sdadc_decim #(.N(N)) u_decim (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_in       (fb_q),
    .result       (result),
    .result_valid (result_valid)
  );

  // R2
  fb_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_q == $past(cmp_sync));

endmodule

// File: tb/sdadc_backend_bench.sv
module sdadc_backend_bench;

  localparam int unsigned N    = 4;
  localparam int unsigned W    = 1 << N;
  localparam int unsigned HALF = 3;

  logic         clk;
  logic         rst_n;
  logic         cmp_in;
  logic         fb_out;
  logic         ref_out;
  logic [N-1:0] result;
  logic         result_valid;

  sdadc_backend #(.N(N), .SYNC_STAGES(2), .REF_HALF_PERIOD(HALF)) u_sdadc_backend (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_in       (cmp_in),
    .fb_out       (fb_out),
    .ref_out      (ref_out),
    .result       (result),
    .result_valid (result_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int           edges;
  int           last_vld_edge;
  int           last_res;
  logic [W-1:0] fbh;
  logic         c1, c2, c3;
  bit           closed;
  int           node;
  int           xin;
  logic [7:0]   lfsr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    cmp_in = v;
    c3 = c2; c2 = c1; c1 = v;
  endtask

  // One clock: observe at the falling edge, then drive the next input.
  task automatic step(input logic drv);
    int sum;
    int exp_res;
    @(negedge clk);
    edges++;
    if (edges >= 3) chk(fb_out == c3, "R2", int'(fb_out), int'(c3));
    chk(ref_out == (((edges / HALF) % 2) == 1), "R3", int'(ref_out), (edges / HALF) % 2);
    chk(result_valid == ((edges % W) == 0), "R4", int'(result_valid), int'((edges % W) == 0));
    if (result_valid) begin
      chk(edges - last_vld_edge == W, "R4", edges - last_vld_edge, W);
      sum     = $countones(fbh);
      exp_res = (sum >= W) ? W - 1 : sum;
      chk(int'(result) == exp_res, "R5", int'(result), exp_res);
      last_vld_edge = edges;
      last_res      = int'(result);
    end else begin
      chk(int'(result) == last_res, "R9", int'(result), last_res);
    end
    fbh = {fbh[W-2:0], fb_out};
    if (closed) begin
      node = node + xin - (fb_out ? W : 0);
      drive(node > 0);
    end else begin
      drive(drv);
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n         = 1'b1;
    edges         = 0;
    last_vld_edge = 0;
    last_res      = 0;
    fbh           = '0;
    node          = 0;
    drive(1'b0);
  endtask

  task automatic run_const(input logic v, input int windows);
    for (int i = 0; i < windows * W; i++) step(v);
  endtask

  initial begin
    rst_n  = 1'b0;
    closed = 0;
    xin    = 0;
    lfsr   = 8'h5a;
    c1 = 0; c2 = 0; c3 = 0;
    cmp_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(fb_out == 0,       "R1", int'(fb_out), 0);
    chk(ref_out == 0,      "R1", int'(ref_out), 0);
    chk(result == 0,       "R1", int'(result), 0);
    chk(result_valid == 0, "R1", int'(result_valid), 0);
    release_reset();

    // All-zero windows
    run_const(1'b0, 2);
    chk(result == 0, "R7", int'(result), 0);

    // All-one windows; first one still carries the pipeline zeros
    run_const(1'b1, 3);
    chk(int'(result) == W - 1, "R6", int'(result), W - 1);

    // Alternating pattern
    for (int i = 0; i < 2 * W; i++) step(i[0]);
    chk(int'(result) == W / 2, "R5", int'(result), W / 2);

    // Pseudo-random pattern
    for (int i = 0; i < 6 * W; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0]);
    end

    // Reset in the middle of a window
    run_const(1'b1, 1);
    for (int i = 0; i < W / 2 + 1; i++) step(1'b1);
    #1 rst_n = 1'b0;
    c1 = 0; c2 = 0; c3 = 0;
    cmp_in = 1'b0;
    @(negedge clk);
    chk(fb_out == 0,       "R1", int'(fb_out), 0);
    chk(ref_out == 0,      "R1", int'(ref_out), 0);
    chk(result == 0,       "R1", int'(result), 0);
    chk(result_valid == 0, "R1", int'(result_valid), 0);
    release_reset();
    run_const(1'b1, 2);
    chk(int'(result) == W - 1, "R6", int'(result), W - 1);

    // Closed loop sweep over every input level
    closed = 1;
    for (int x = 0; x <= W; x++) begin
      int acc;
      int target;
      xin = x;
      node = 0;
      run_const(1'b0, 2);
      acc = 0;
      for (int w = 0; w < 16; w++) begin
        run_const(1'b0, 1);
        acc += int'(result);
      end
      target = (x >= W) ? (W - 1) * 16 : x * 16;
      chk((acc - target) <= 32 && (target - acc) <= 32, "R8", acc, target);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule